// File: doc/BRIEF.md
# Prioritized Interrupt Controller Register Block

This block collects 32 interrupt lines and presents the most urgent one to a processor. Software reaches its state through a simple 32-bit register bus with a valid strobe and a write flag. Each line has an enable bit and a pending bit. Each bit is changed through a pair of registers: writing 1 to one of the pair sets the bit, and writing 1 to the other clears it. A 2-bit priority is held per line, and four lines are packed into each of eight priority registers.

A rising edge on a hardware interrupt input makes that line pending. A combinational arbiter looks at every line that is both enabled and pending and picks the one with the smallest priority value. It then drives a request flag, the winning line number and a vector number equal to the line number plus 16. The processor acknowledges a line by presenting its number on an acknowledge strobe, and that clears the line's pending bit.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads 0 and irq_req, irq_num and vector are 0. All lines start disabled and not pending, and each has priority value 0.
- R2: A write to offset 0x000 sets each enable bit n for which data bit n is 1. Data bits that are 0 leave the matching enable bit unchanged.
- R3: A write to offset 0x080 clears each enable bit n for which data bit n is 1. Reads at 0x000 and at 0x080 both return the 32 enable bits, with bit n belonging to line n.
- R4: A write to offset 0x100 sets pending bits where the data is 1, and a write to offset 0x180 clears pending bits where the data is 1. Reads at either offset return the 32 pending bits.
- R5: Priority register k is at offset 0x300+4k, for k from 0 to 7. It holds the priority of line 4k+j in bits [8j+7:8j+6], for j from 0 to 3. Every other bit reads 0, and writing it has no effect.
- R6: A 0-to-1 transition on irq_in[n], seen at a clock edge, sets pending bit n whatever the enable state. An input that simply stays high does not set the bit again after it has been cleared.
- R7: If a hardware edge and a clearing write or acknowledge hit the same pending bit in the same cycle, the bit ends up set.
- R8: Only lines that are both enabled and pending compete. The winner has the numerically smallest priority value, and a tie goes to the lowest line number.
- R9: When a line wins, irq_req is 1, irq_num is its number and vector is irq_num+16. When no line is both enabled and pending, all three outputs are 0.
- R10: An ack_valid pulse with ack_num = n clears pending bit n at the next clock edge.
- R11: A read from any offset not listed in R2 to R5 returns 0. This includes offsets in the priority window that are not multiples of 4. A write to such an offset changes no state.
- R12: bus_rdata is combinational and shows the addressed register in the same cycle in which bus_valid is 1 and bus_write is 0. At all other times it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| irq_in | input | 32 | Hardware interrupt lines, edge captured |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_num | input | 5 | Line number being acknowledged |
| irq_req | output | 1 | A line is enabled and pending |
| irq_num | output | 5 | Winning line number |
| vector | output | 6 | Winning vector number (irq_num+16) |

## Verification
The assertions check the following on every cycle:
- the effect of a set-enable or clear-enable write on the enable bits;
- the capture of hardware edges, including an edge winning over a clear;
- acknowledge clearing;
- that the reported winner is active and that no active line beats it;
- that read data is 0 for unmapped offsets and when no read is in progress.

Only the bench scenarios can show the reset values and the packing of the priority fields into register bits. The same is true for writes to unmapped offsets leaving every register intact, and for a held input level not pending a line again. Random traffic compares read-back and arbitration against a reference model over long mixes of writes, edges and acknowledges.

// File: rtl/prio_irq_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the prioritized interrupt controller.
// Assumes a byte-addressed register bus whose registers are 32 bits wide.
package prio_irq_pkg;

    // Register offsets: the layout the software driver decodes
    localparam int OFS_EN_SET    = 'h000;
    localparam int OFS_EN_CLR    = 'h080;
    localparam int OFS_PD_SET    = 'h100;
    localparam int OFS_PD_CLR    = 'h180;
    localparam int OFS_PRIO_BASE = 'h300;

    // Register selected by the address decoder
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_EN_SET,
        SEL_EN_CLR,
        SEL_PD_SET,
        SEL_PD_CLR,
        SEL_PRIO
    } reg_sel_e;

endpackage

// File: rtl/irq_addr_decode.sv
`timescale 1ns/1ps
// Address decoder: maps a byte offset onto a register selector and, for the
// priority window, a register index. Needs an exact offset match; offsets in
// the priority window that are not multiples of 4 decode as SEL_NONE.
module irq_addr_decode
    import prio_irq_pkg::*;
#(
    parameter int ADDR_W        = 12,
    parameter int NUM_PRIO_REGS = 8,
    localparam int IDX_W        = (NUM_PRIO_REGS > 1) ? $clog2(NUM_PRIO_REGS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [IDX_W-1:0]  prio_idx
);

    localparam logic [ADDR_W-1:0] PRIO_LO = ADDR_W'(OFS_PRIO_BASE);
    localparam logic [ADDR_W-1:0] PRIO_HI = ADDR_W'(OFS_PRIO_BASE + 4 * NUM_PRIO_REGS);

    logic [ADDR_W-1:0] prio_ofs;

    // Offset within the priority window, in bytes
    assign prio_ofs = addr - PRIO_LO;
    assign prio_idx = IDX_W'(prio_ofs >> 2);

    // Pick the register that the offset names
    always_comb begin
        sel = SEL_NONE;
        if (addr == ADDR_W'(OFS_EN_SET))      sel = SEL_EN_SET;
        else if (addr == ADDR_W'(OFS_EN_CLR)) sel = SEL_EN_CLR;
        else if (addr == ADDR_W'(OFS_PD_SET)) sel = SEL_PD_SET;
        else if (addr == ADDR_W'(OFS_PD_CLR)) sel = SEL_PD_CLR;
        else if (addr >= PRIO_LO && addr < PRIO_HI && addr[1:0] == 2'b00)
            sel = SEL_PRIO;
    end

endmodule

// File: rtl/irq_edge_capture.sv
`timescale 1ns/1ps
// Rising-edge detector for the hardware interrupt lines. Assumes irq_in is
// already synchronous to clk. Gives a one-cycle set request per 0-to-1 change.
module irq_edge_capture #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic [NUM_LINES-1:0] rise
);

    logic [NUM_LINES-1:0] prev_q;

    // Remember the level of each line from the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= irq_in;
    end

    assign rise = irq_in & ~prev_q;

endmodule

// File: rtl/irq_state_regs.sv
`timescale 1ns/1ps
// Enable, pending and priority storage with the read-back multiplexer.
// Assumes NUM_LINES equals DATA_W, so one register bit maps to each line.
// A set request (software or hardware) beats any clear in the same cycle.
module irq_state_regs
    import prio_irq_pkg::*;
#(
    parameter int NUM_LINES     = 32,
    parameter int PRIO_W        = 2,
    parameter int DATA_W        = 32,
    localparam int NUM_W        = $clog2(NUM_LINES),
    localparam int LPR          = DATA_W / 8,
    localparam int NUM_PRIO_REGS = NUM_LINES / LPR,
    localparam int IDX_W        = (NUM_PRIO_REGS > 1) ? $clog2(NUM_PRIO_REGS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  reg_sel_e                    sel,
    input  logic [IDX_W-1:0]            prio_idx,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           rdata,
    input  logic [NUM_LINES-1:0]        hw_set,
    input  logic                        ack_valid,
    input  logic [NUM_W-1:0]            ack_num,
    output logic [NUM_LINES-1:0]        en_q,
    output logic [NUM_LINES-1:0]        pend_q,
    output logic [NUM_LINES*PRIO_W-1:0] prio_flat
);

    logic [NUM_LINES-1:0] en_set, en_clr, pd_set, pd_clr, ack_mask, set_any;

    // Turn the bus write into per-line set and clear masks
    always_comb begin
        en_set = (wr_en && sel == SEL_EN_SET) ? wdata[NUM_LINES-1:0] : '0;
        en_clr = (wr_en && sel == SEL_EN_CLR) ? wdata[NUM_LINES-1:0] : '0;
        pd_set = (wr_en && sel == SEL_PD_SET) ? wdata[NUM_LINES-1:0] : '0;
        pd_clr = (wr_en && sel == SEL_PD_CLR) ? wdata[NUM_LINES-1:0] : '0;
    end

    // One-hot mask of the acknowledged line
    always_comb begin
        ack_mask = '0;
        if (ack_valid) ack_mask[ack_num] = 1'b1;
    end

    assign set_any = pd_set | hw_set;

    // Enable bits: write-one-to-set and write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= (en_q & ~en_clr) | en_set;
    end

    // Pending bits: clears first, then sets on top so that a set wins
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~(pd_clr | ack_mask)) | set_any;
    end

    // One priority field per line, loaded from the top bits of its byte
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_prio
        localparam int REG_I = g / LPR;
        localparam int LSB   = (g % LPR) * 8 + 8 - PRIO_W;
        logic [PRIO_W-1:0] prio_q;

        // Load this line's field when its register is written
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_q <= '0;
            else if (wr_en && sel == SEL_PRIO && prio_idx == IDX_W'(REG_I))
                prio_q <= wdata[LSB +: PRIO_W];
        end

        assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q;
    end

    // Read-back multiplexer; zero when idle or unmapped
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_EN_SET, SEL_EN_CLR: rdata[NUM_LINES-1:0] = en_q;
                SEL_PD_SET, SEL_PD_CLR: rdata[NUM_LINES-1:0] = pend_q;
                SEL_PRIO: begin
                    for (int j = 0; j < LPR; j++)
                        rdata[j*8+8-PRIO_W +: PRIO_W] =
                            prio_flat[(int'(prio_idx)*LPR + j)*PRIO_W +: PRIO_W];
                end
                default: rdata = '0;
            endcase
        end
    end

    // R2: the lines written as 1 at the set-enable offset are enabled afterwards
    assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_EN_SET) |=>
            ((en_q & $past(wdata[NUM_LINES-1:0])) == $past(wdata[NUM_LINES-1:0])));

    // R3: the lines written as 1 at the clear-enable offset are disabled afterwards
    assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_EN_CLR) |=>
            ((en_q & $past(wdata[NUM_LINES-1:0])) == '0));

    // R6, R7: a hardware edge leaves its pending bit set, whatever else happens
    assert_hw_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_set) |=> ((pend_q & $past(hw_set)) == $past(hw_set)));

    // R10: an acknowledge clears the pending bit unless a set collides with it
    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !set_any[ack_num]) |=> !pend_q[$past(ack_num)]);

endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
// Combinational arbiter. Scans the lines in ascending order and keeps a
// candidate only while no earlier active line has a smaller or equal priority
// value, so a tie goes to the lowest line number. Outputs are 0 when idle.
module irq_arbiter #(
    parameter int NUM_LINES  = 32,
    parameter int PRIO_W     = 2,
    parameter int VEC_OFFSET = 16,
    localparam int NUM_W     = $clog2(NUM_LINES),
    localparam int VEC_W     = $clog2(NUM_LINES + VEC_OFFSET)
) (
    input  logic [NUM_LINES-1:0]        en,
    input  logic [NUM_LINES-1:0]        pend,
    input  logic [NUM_LINES*PRIO_W-1:0] prio_flat,
    output logic                        req,
    output logic [NUM_W-1:0]            num,
    output logic [VEC_W-1:0]            vector
);

    logic [NUM_LINES-1:0] active;
    logic                 found;
    logic [PRIO_W-1:0]    best_prio;
    logic [NUM_W-1:0]     best_idx;

    assign active = en & pend;

    // Linear minimum search over the active lines
    always_comb begin
        found     = 1'b0;
        best_prio = '0;
        best_idx  = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (active[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] < best_prio)) begin
                found     = 1'b1;
                best_prio = prio_flat[i*PRIO_W +: PRIO_W];
                best_idx  = NUM_W'(i);
            end
        end
    end

    // Drive the request, the line number and the vector number
    always_comb begin
        req    = found;
        num    = best_idx;
        vector = found ? (VEC_W'(best_idx) + VEC_W'(VEC_OFFSET)) : '0;
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
// Top level of the prioritized interrupt controller. It joins the decoder,
// the edge capture, the state registers and the arbiter. It assumes a
// single-cycle register bus: a write takes effect at the clock edge where
// bus_valid and bus_write are both high, and a read returns data in the
// same cycle.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NUM_LINES  = 32,
    parameter int PRIO_W     = 2,
    parameter int VEC_OFFSET = 16,
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    localparam int NUM_W     = $clog2(NUM_LINES),
    localparam int VEC_W     = $clog2(NUM_LINES + VEC_OFFSET),
    localparam int LPR       = DATA_W / 8,
    localparam int NUM_PRIO_REGS = NUM_LINES / LPR,
    localparam int IDX_W     = (NUM_PRIO_REGS > 1) ? $clog2(NUM_PRIO_REGS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 ack_valid,
    input  logic [NUM_W-1:0]     ack_num,
    output logic                 irq_req,
    output logic [NUM_W-1:0]     irq_num,
    output logic [VEC_W-1:0]     vector
);

    reg_sel_e                    sel;
    logic [IDX_W-1:0]            prio_idx;
    logic [NUM_LINES-1:0]        rise, en_q, pend_q;
    logic [NUM_LINES*PRIO_W-1:0] prio_flat;
    logic                        wr_en, rd_en;
    logic [PRIO_W-1:0]           win_prio;

    assign wr_en = bus_valid && bus_write;
    assign rd_en = bus_valid && !bus_write;

    irq_addr_decode #(
        .ADDR_W        (ADDR_W),
        .NUM_PRIO_REGS (NUM_PRIO_REGS)
    ) u_decode (
        .addr     (bus_addr),
        .sel      (sel),
        .prio_idx (prio_idx)
    );

    irq_edge_capture #(
        .NUM_LINES (NUM_LINES)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_in (irq_in),
        .rise   (rise)
    );

    irq_state_regs #(
        .NUM_LINES (NUM_LINES),
        .PRIO_W    (PRIO_W),
        .DATA_W    (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .sel       (sel),
        .prio_idx  (prio_idx),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .hw_set    (rise),
        .ack_valid (ack_valid),
        .ack_num   (ack_num),
        .en_q      (en_q),
        .pend_q    (pend_q),
        .prio_flat (prio_flat)
    );

    irq_arbiter #(
        .NUM_LINES  (NUM_LINES),
        .PRIO_W     (PRIO_W),
        .VEC_OFFSET (VEC_OFFSET)
    ) u_arb (
        .en        (en_q),
        .pend      (pend_q),
        .prio_flat (prio_flat),
        .req       (irq_req),
        .num       (irq_num),
        .vector    (vector)
    );

    assign win_prio = prio_flat[irq_num*PRIO_W +: PRIO_W];

    // R8: a reported winner is enabled and pending
    assert_winner_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (en_q[irq_num] && pend_q[irq_num]));

    // R9: with no request, the number and the vector are 0 and no line is active
    assert_idle_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> ((en_q & pend_q) == '0 && irq_num == '0 && vector == '0));

    // R8: no active line beats the winner on value or, on a tie, on index
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_best_chk
        assert_winner_best_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_req && en_q[g] && pend_q[g]) |->
                (prio_flat[g*PRIO_W +: PRIO_W] > win_prio ||
                 (prio_flat[g*PRIO_W +: PRIO_W] == win_prio && g >= int'(irq_num))));
    end

    // R11: a read at an unmapped offset returns 0
    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_NONE) |-> (bus_rdata == '0));

    // R12: read data is 0 whenever no read is in progress
    assert_idle_rdata_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (bus_rdata == '0));

endmodule

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases followed by seeded random
// traffic, compared against a reference model built from the requirements.
module prio_irq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_valid = 1'b0;
    logic        b_write = 1'b0;
    logic [11:0] b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] b_rdata;
    logic [31:0] irq_in = '0;
    logic        ack_v = 1'b0;
    logic [4:0]  ack_n = '0;
    logic        irq_req;
    logic [4:0]  irq_num;
    logic [5:0]  vector;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (b_valid),
        .bus_write (b_write),
        .bus_addr  (b_addr),
        .bus_wdata (b_wdata),
        .bus_rdata (b_rdata),
        .irq_in    (irq_in),
        .ack_valid (ack_v),
        .ack_num   (ack_n),
        .irq_req   (irq_req),
        .irq_num   (irq_num),
        .vector    (vector)
    );

    // Reference model state
    logic [31:0] m_en, m_pd, m_prev;
    logic [1:0]  m_pr [32];
    logic [31:0] t_ps, t_pc, t_am;

    // Model update at each edge, from the same inputs the design sees
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en <= '0; m_pd <= '0; m_prev <= '0;
            for (int i = 0; i < 32; i++) m_pr[i] <= '0;
        end else begin
            t_ps = '0; t_pc = '0; t_am = '0;
            if (b_valid && b_write) begin
                if (b_addr == 12'h000) m_en <= m_en | b_wdata;
                else if (b_addr == 12'h080) m_en <= m_en & ~b_wdata;
                else if (b_addr == 12'h100) t_ps = b_wdata;
                else if (b_addr == 12'h180) t_pc = b_wdata;
                else if (b_addr >= 12'h300 && b_addr < 12'h320 && b_addr[1:0] == 2'b00)
                    for (int j = 0; j < 4; j++)
                        m_pr[(b_addr - 12'h300) / 4 * 4 + j] <= b_wdata[j*8+6 +: 2];
            end
            if (ack_v) t_am[ack_n] = 1'b1;
            m_pd   <= (m_pd & ~(t_pc | t_am)) | t_ps | (irq_in & ~m_prev);
            m_prev <= irq_in;
        end
    end

    function automatic logic [31:0] model_read(input logic [11:0] a);
        logic [31:0] r = '0;
        if (a == 12'h000 || a == 12'h080) r = m_en;
        else if (a == 12'h100 || a == 12'h180) r = m_pd;
        else if (a >= 12'h300 && a < 12'h320 && a[1:0] == 2'b00)
            for (int j = 0; j < 4; j++) r[j*8+6 +: 2] = m_pr[(a - 12'h300) / 4 * 4 + j];
        return r;
    endfunction

    // Expected {req, num}: lowest value wins, ties to the lowest number
    function automatic logic [5:0] model_arb();
        logic       f = 1'b0;
        logic [1:0] bp = '0;
        logic [4:0] bi = '0;
        for (int i = 0; i < 32; i++)
            if (m_en[i] && m_pd[i] && (!f || m_pr[i] < bp)) begin
                f = 1'b1; bp = m_pr[i]; bi = 5'(i);
            end
        return {f, bi};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_out(input string tag);
        logic [5:0] e;
        e = model_arb();
        chk({tag, " req"}, 32'(irq_req), 32'(e[5]));
        chk({tag, " num"}, 32'(irq_num), 32'(e[4:0]));
        chk({tag, " vector"}, 32'(vector), e[5] ? 32'(e[4:0]) + 32'd16 : 32'd0);
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        b_valid = 1'b1; b_write = 1'b1; b_addr = a; b_wdata = d;
        @(negedge clk);
        b_valid = 1'b0; b_write = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        b_valid = 1'b1; b_write = 1'b0; b_addr = a;
        #1;
        chk(tag, b_rdata, exp);
        b_valid = 1'b0;
    endtask

    task automatic expect_out(input string tag, input logic r, input logic [4:0] n, input logic [5:0] v);
        @(negedge clk);
        #1;
        chk({tag, " req"}, 32'(irq_req), 32'(r));
        chk({tag, " num"}, 32'(irq_num), 32'(n));
        chk({tag, " vector"}, 32'(vector), 32'(v));
    endtask

    function automatic logic [11:0] pick_addr(input int unsigned k);
        case (k % 14)
            0: return 12'h000;  1: return 12'h080;
            2: return 12'h100;  3: return 12'h180;
            12: return 12'h004; 13: return 12'h322;
            default: return 12'h300 + 12'((k % 14 - 4) * 4);
        endcase
    endfunction

    // Watchdog: a hung run is reported as a failed check
    initial begin
        #1600000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of all registers and outputs
        rd_chk("R1 en_set", 12'h000, 32'h0);
        rd_chk("R1 en_clr", 12'h080, 32'h0);
        rd_chk("R1 pd_set", 12'h100, 32'h0);
        rd_chk("R1 pd_clr", 12'h180, 32'h0);
        for (int k = 0; k < 8; k++) rd_chk("R1 prio", 12'h300 + 12'(k*4), 32'h0);
        expect_out("R1 outputs", 1'b0, 5'd0, 6'd0);

        // R2: set-enable, and zero bits leave enables alone
        bus_wr(12'h000, 32'h0000_00F0);
        rd_chk("R2 set", 12'h000, 32'h0000_00F0);
        bus_wr(12'h000, 32'h0);
        rd_chk("R2 zero write", 12'h000, 32'h0000_00F0);

        // R3: clear-enable, read back at both offsets
        bus_wr(12'h080, 32'h0000_0030);
        rd_chk("R3 clr read", 12'h080, 32'h0000_00C0);
        rd_chk("R3 set read", 12'h000, 32'h0000_00C0);

        // R4: pending set and clear
        bus_wr(12'h100, 32'h8000_0041);
        rd_chk("R4 pend read", 12'h180, 32'h8000_0041);
        bus_wr(12'h180, 32'h0000_0001);
        rd_chk("R4 pend clr", 12'h100, 32'h8000_0040);

        // R5: priority packing; the unused bits read 0
        bus_wr(12'h304, 32'hFFFF_FFFF);
        rd_chk("R5 all ones", 12'h304, 32'hC0C0_C0C0);
        bus_wr(12'h31C, 32'h4080_00C0);
        rd_chk("R5 mixed", 12'h31C, 32'h4080_00C0);
        rd_chk("R5 neighbour", 12'h300, 32'h0);

        // R8, R9: line 6 (priority 3) is the only active line
        expect_out("R9 single", 1'b1, 5'd6, 6'd22);
        // R8: line 31 (priority 1) beats line 6 (priority 3)
        bus_wr(12'h000, 32'h8000_0000);
        expect_out("R8 value", 1'b1, 5'd31, 6'd47);
        // R8: tie between lines 6 and 7 goes to 6
        bus_wr(12'h080, 32'h8000_0000);
        bus_wr(12'h100, 32'h0000_0080);
        expect_out("R8 tie", 1'b1, 5'd6, 6'd22);

        // R10: acknowledge clears at the next edge
        @(negedge clk);
        ack_v = 1'b1; ack_n = 5'd6;
        #1;
        chk("R10 before edge", 32'(irq_num), 32'd6);
        @(negedge clk);
        ack_v = 1'b0;
        #1;
        chk("R10 after edge", 32'(irq_num), 32'd7);
        rd_chk("R10 pend", 12'h100, 32'h8000_0080);

        // R6: edge pends a disabled line; the held level does not pend it again
        @(negedge clk);
        irq_in[10] = 1'b1;
        rd_chk("R6 edge", 12'h100, 32'h8000_0480);
        bus_wr(12'h180, 32'h0000_0400);
        repeat (2) @(negedge clk);
        rd_chk("R6 held level", 12'h100, 32'h8000_0080);

        // R7: hardware edge and software clear in the same cycle
        @(negedge clk);
        irq_in[12] = 1'b1;
        b_valid = 1'b1; b_write = 1'b1; b_addr = 12'h180; b_wdata = 32'h0000_1000;
        @(negedge clk);
        b_valid = 1'b0; b_write = 1'b0;
        rd_chk("R7 set wins", 12'h100, 32'h8000_1080);

        // R11: unmapped writes change nothing and unmapped reads return 0
        bus_wr(12'h004, 32'hFFFF_FFFF);
        bus_wr(12'h320, 32'hFFFF_FFFF);
        bus_wr(12'h302, 32'hFFFF_FFFF);
        rd_chk("R11 enable intact", 12'h000, 32'h0000_00C0);
        rd_chk("R11 pend intact", 12'h100, 32'h8000_1080);
        rd_chk("R11 prio intact", 12'h300, 32'h0);
        rd_chk("R11 read 004", 12'h004, 32'h0);
        rd_chk("R11 read 320", 12'h320, 32'h0);
        rd_chk("R11 read 302", 12'h302, 32'h0);
        rd_chk("R11 read FFC", 12'hFFC, 32'h0);

        // R12: rdata is 0 outside a read
        @(negedge clk);
        b_addr = 12'h000; b_valid = 1'b0;
        #1;
        chk("R12 no strobe", b_rdata, 32'h0);
        b_valid = 1'b1; b_write = 1'b1; b_wdata = 32'h0;
        #1;
        chk("R12 write cycle", b_rdata, 32'h0);
        @(negedge clk);
        b_valid = 1'b0; b_write = 1'b0;

        // R9: everything disabled gives idle outputs
        bus_wr(12'h080, 32'hFFFF_FFFF);
        expect_out("R9 idle", 1'b0, 5'd0, 6'd0);

        // Random traffic against the model (R4, R5, R6, R8, R10, R11)
        for (int it = 0; it < 1500; it++) begin
            int unsigned op;
            @(negedge clk);
            op = $urandom % 4;
            b_valid = 1'b0; b_write = 1'b0;
            if (op == 0) begin
                b_valid = 1'b1; b_write = 1'b1;
                b_addr = pick_addr($urandom);
                b_wdata = $urandom;
            end else if (op == 1) begin
                b_valid = 1'b1;
                b_addr = pick_addr($urandom);
            end
            irq_in = irq_in ^ ($urandom & $urandom & $urandom);
            ack_v = ($urandom % 5) == 0;
            ack_n = 5'($urandom);
            #1;
            chk_out("R8 random");
            if (op == 1) chk("R11 random read", b_rdata, model_read(b_addr));
        end
        @(negedge clk);
        b_valid = 1'b0; b_write = 1'b0; ack_v = 1'b0;
        @(negedge clk);
        #1;
        chk_out("R10 random final");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule